// File: doc/BRIEF.md
# PCI Configuration Access Port

This block gives a host processor indirect access to the configuration space of devices spread over a small tree of PCI buses. The processor sees two 32-bit registers selected by a one-bit offset: an address latch at offset 0 and a data window at offset 1. Writing the latch with its top bit set names a target bus, device, function and dword register. The block then searches a fixed tree: the local root bus first, then up to eight child buses in their configured order. The first bus whose number matches becomes the selected bus, and the device number is kept with it.

Reads and writes of the data window turn into single-cycle configuration requests on a target-side port. Each request carries the selected bus and device, the function and register fields of the current latch, the write data and the byte mask. The target answers a read one cycle later. A missing bus, or a device slot that the selected bus does not populate, reads as all ones and drops writes. The selected target stays in place between accesses. An address write with the top bit clear changes the latch and the function/register fields, but it leaves the bus and device selection untouched.

Top module: `cfg_access_port`

## Requirements
- R1: A read at offset 0 returns the last value written to the address latch, every bit unchanged (enable bit, reserved bits and bits 1:0 included).
- R2: A read (`cpu_rd` high, `cpu_wr` low) produces `cpu_rvalid` high for exactly one cycle, in the cycle after the strobe, with `cpu_rdata` valid in that cycle.
- R3: Latch fields: enable = bit 31, bus = bits 23:16, device = bits 15:11, function = bits 10:8, register = bits 7:2. A data-window request drives `tgt_reg` = {bits 7:2, 2'b00}. The bus and device are taken from the most recent latch write that had bit 31 set.
- R4: A latch write with bit 31 clear updates the latch and the function/register used by later requests, and leaves the selected bus, device and valid state unchanged.
- R5: The lookup compares the root bus number first and then children 0, 1, 2, ... in order. The first match selects that bus's slot map, even when a later bus has the same number.
- R6: If no bus in the tree matches, the target is invalid. Data-window reads then return 32'hFFFFFFFF and issue no request, and data-window writes issue no request.
- R7: On a matched bus whose slot map has a 0 at the selected device number, data-window reads return 32'hFFFFFFFF and writes are dropped, with no request in either case.
- R8: A request to a populated slot passes `cpu_be` to `tgt_be` unchanged on both reads and writes. On a write it also passes `cpu_wdata` to `tgt_wdata` with `tgt_we` = 1. On a read `tgt_we` = 0, and `cpu_rdata` in the return cycle equals `tgt_rdata`.
- R9: Synchronous active-high reset clears the latch to zero and marks the target invalid.
- R10: `tgt_req` is high only in a cycle with a data-window (offset 1) access to a valid, populated target. Offset 0 accesses never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_off | input | 1 | Register select: 0 address latch, 1 data window |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe (wins over a simultaneous read) |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte mask |
| cpu_rdata | output | 32 | Read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data valid, one cycle after cpu_rd |
| tgt_req | output | 1 | Configuration request strobe |
| tgt_we | output | 1 | 1 write, 0 read |
| tgt_bus | output | 8 | Selected bus number |
| tgt_dev | output | 5 | Selected device number |
| tgt_fn | output | 3 | Function number |
| tgt_reg | output | 8 | Dword-aligned register offset |
| tgt_wdata | output | 32 | Write data to the target |
| tgt_be | output | 4 | Byte mask to the target |
| tgt_rdata | input | 32 | Target read data, one cycle after a read request |

## Verification
The default tree is built to separate the possible search orders. The root and child 1 both claim bus 0, and children 0 and 2 both claim bus 2, each pair with a different slot map. A read that returns data rather than all ones therefore shows which bus won the search. Address patterns with junk in bits 1:0 and in the reserved bits separate the unchanged latch readback from the dword-aligned register offset. Latch writes with the enable bit clear that follow hit, miss and unpopulated selections show that the selection is kept while the function and register fields follow the latch. A reset taken mid-run, after a valid target was selected, separates a true target invalidation from a simple latch clear.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam int BUS_W     = 8;
    localparam int DEV_W     = 5;
    localparam int FN_W      = 3;
    localparam int DWORD_W   = 6;
    localparam int REG_W     = DWORD_W + 2;
    localparam int MAX_CHILD = 8;
    localparam int N_SLOT    = 1 << DEV_W;
    localparam int IDX_W     = $clog2(MAX_CHILD + 1);

    // Field positions are fixed by the access protocol.
    typedef struct packed {
        logic               en;
        logic [6:0]         rsvd;
        logic [BUS_W-1:0]   bus;
        logic [DEV_W-1:0]   dev;
        logic [FN_W-1:0]    fn;
        logic [DWORD_W-1:0] dword;
        logic [1:0]         low;
    } cfg_addr_t;

    typedef struct packed {
        logic               valid;
        logic [BUS_W-1:0]   bus;
        logic [DEV_W-1:0]   dev;
        logic [IDX_W-1:0]   idx;
    } tgt_sel_t;

    typedef enum logic [1:0] {
        RSRC_IDLE   = 2'd0,
        RSRC_HOLD   = 2'd1,
        RSRC_TARGET = 2'd2
    } rd_src_e;

    function automatic logic [REG_W-1:0] reg_offset(input cfg_addr_t a);
        return {a.dword, 2'b00};
    endfunction

endpackage

// File: rtl/cfg_bus_lookup.sv
module cfg_bus_lookup
    import cfg_port_pkg::*;
#(
    parameter int                         N_CHILD   = 3,
    parameter logic [BUS_W-1:0]           ROOT_BUS  = '0,
    parameter logic [MAX_CHILD*BUS_W-1:0] CHILD_BUS = '0
) (
    input  logic [BUS_W-1:0] bus_num,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    localparam int N_BUS = N_CHILD + 1;

    logic [N_BUS-1:0] match;

    assign match[0] = (bus_num == ROOT_BUS);

    generate
        for (genvar c = 0; c < N_CHILD; c++) begin : g_child
            assign match[c+1] = (bus_num == CHILD_BUS[c*BUS_W +: BUS_W]);
        end
    endgenerate

    // Lowest index wins: root, then children in order.
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = N_BUS - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/cfg_slot_table.sv
module cfg_slot_table
    import cfg_port_pkg::*;
#(
    parameter int                          N_BUS    = 4,
    parameter logic [N_BUS*N_SLOT-1:0]     SLOT_MAP = '0
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [DEV_W-1:0] dev,
    output logic             populated
);
    logic [N_SLOT-1:0] row [N_BUS];

    generate
        for (genvar b = 0; b < N_BUS; b++) begin : g_row
            assign row[b] = SLOT_MAP[b*N_SLOT +: N_SLOT];
        end
    endgenerate

    always_comb begin
        populated = 1'b0;
        for (int b = 0; b < N_BUS; b++) begin
            if (idx == IDX_W'(b)) populated = row[b][dev];
        end
    end

endmodule

// File: rtl/cfg_target_reg.sv
module cfg_target_reg
    import cfg_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_wr,
    input  cfg_addr_t        addr_in,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    output cfg_addr_t        addr_q,
    output tgt_sel_t         sel_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            sel_q  <= '0;
        end else if (addr_wr) begin
            addr_q <= addr_in;
            if (addr_in.en) begin
                sel_q.valid <= hit;
                sel_q.bus   <= addr_in.bus;
                sel_q.dev   <= addr_in.dev;
                sel_q.idx   <= hit_idx;
            end
        end
    end

    // R4: a latch write without the enable bit keeps the selection
    assert_keep_selection_R4: assert property (@(posedge clk) disable iff (rst)
        (addr_wr && !addr_in.en) |=> $stable(sel_q));

    // R9: reset leaves an empty latch and no valid target
    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (addr_q == '0 && !sel_q.valid));

endmodule

// File: rtl/cfg_read_return.sv
module cfg_read_return
    import cfg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_fire,
    input  logic              from_target,
    input  logic [DATA_W-1:0] hold_in,
    input  logic [DATA_W-1:0] tgt_rdata,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    rd_src_e           src_q;
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= RSRC_IDLE;
            hold_q <= '0;
        end else if (rd_fire) begin
            src_q  <= from_target ? RSRC_TARGET : RSRC_HOLD;
            hold_q <= hold_in;
        end else begin
            src_q  <= RSRC_IDLE;
        end
    end

    assign rvalid = (src_q != RSRC_IDLE);
    assign rdata  = (src_q == RSRC_TARGET) ? tgt_rdata : hold_q;

    // R2: every read strobe yields a response in the next cycle
    assert_read_returns_R2: assert property (@(posedge clk) disable iff (rst)
        rd_fire |=> rvalid);

    // R2: no response appears without a read one cycle earlier
    assert_no_spurious_rvalid_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_fire |=> !rvalid);

endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
    import cfg_port_pkg::*;
#(
    parameter int                           N_CHILD   = 3,
    parameter logic [BUS_W-1:0]             ROOT_BUS  = 8'd0,
    parameter logic [MAX_CHILD*BUS_W-1:0]   CHILD_BUS = 64'h0000_0000_0002_0002,
    parameter logic [(N_CHILD+1)*N_SLOT-1:0] SLOT_MAP =
        128'h0000_0100_FFFF_FFFF_0000_0008_0000_0013
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_off,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic              tgt_req,
    output logic              tgt_we,
    output logic [BUS_W-1:0]  tgt_bus,
    output logic [DEV_W-1:0]  tgt_dev,
    output logic [FN_W-1:0]   tgt_fn,
    output logic [REG_W-1:0]  tgt_reg,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic [BE_W-1:0]   tgt_be,
    input  logic [DATA_W-1:0] tgt_rdata
);
    localparam int N_BUS = N_CHILD + 1;

    cfg_addr_t        addr_in;
    cfg_addr_t        addr_q;
    tgt_sel_t         sel_q;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             populated;
    logic             live;
    logic             addr_wr, data_wr, rd_fire, data_rd;
    logic [DATA_W-1:0] hold_val;

    assign addr_in = cfg_addr_t'(cpu_wdata);
    assign addr_wr = cpu_wr && !cpu_off;
    assign data_wr = cpu_wr &&  cpu_off;
    assign rd_fire = cpu_rd && !cpu_wr;
    assign data_rd = rd_fire && cpu_off;

    cfg_bus_lookup #(
        .N_CHILD  (N_CHILD),
        .ROOT_BUS (ROOT_BUS),
        .CHILD_BUS(CHILD_BUS)
    ) u_lookup (
        .bus_num(addr_in.bus),
        .hit    (hit),
        .idx    (hit_idx)
    );

    cfg_target_reg u_target (
        .clk    (clk),
        .rst    (rst),
        .addr_wr(addr_wr),
        .addr_in(addr_in),
        .hit    (hit),
        .hit_idx(hit_idx),
        .addr_q (addr_q),
        .sel_q  (sel_q)
    );

    cfg_slot_table #(
        .N_BUS   (N_BUS),
        .SLOT_MAP(SLOT_MAP)
    ) u_slots (
        .idx      (sel_q.idx),
        .dev      (sel_q.dev),
        .populated(populated)
    );

    assign live = sel_q.valid && populated;

    // Target request: single-cycle, combinational from the CPU strobe.
    assign tgt_req   = (data_rd || data_wr) && live;
    assign tgt_we    = data_wr;
    assign tgt_bus   = sel_q.bus;
    assign tgt_dev   = sel_q.dev;
    assign tgt_fn    = addr_q.fn;
    assign tgt_reg   = reg_offset(addr_q);
    assign tgt_wdata = cpu_wdata;
    assign tgt_be    = cpu_be;

    assign hold_val = cpu_off ? '1 : DATA_W'(addr_q);

    cfg_read_return u_return (
        .clk        (clk),
        .rst        (rst),
        .rd_fire    (rd_fire),
        .from_target(cpu_off && live),
        .hold_in    (hold_val),
        .tgt_rdata  (tgt_rdata),
        .rvalid     (cpu_rvalid),
        .rdata      (cpu_rdata)
    );

    // R10: requests only come from data-window accesses
    assert_req_only_window_R10: assert property (@(posedge clk) disable iff (rst)
        tgt_req |-> (cpu_off && (cpu_rd || cpu_wr)));

    // R6: no request while the selected target is invalid
    assert_no_req_invalid_R6: assert property (@(posedge clk) disable iff (rst)
        !sel_q.valid |-> !tgt_req);

    // R7: a window read that raised no request returns all ones
    assert_ones_default_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && cpu_off && !tgt_req) |=> (cpu_rdata == '1));

    // R1: a latch read returns the latch as it stood at the read
    assert_latch_readback_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && !cpu_off) |=> (cpu_rdata == DATA_W'($past(addr_q))));

endmodule

// File: tb/cfg_access_port_test.sv
module cfg_access_port_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        we;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [7:0]  rg;
        logic [31:0] data;
        logic [3:0]  be;
    } req_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_off = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_rvalid;
    logic        tgt_req, tgt_we;
    logic [7:0]  tgt_bus;
    logic [4:0]  tgt_dev;
    logic [2:0]  tgt_fn;
    logic [7:0]  tgt_reg;
    logic [31:0] tgt_wdata;
    logic [3:0]  tgt_be;
    logic [31:0] tgt_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [31:0] rd_exp_q[$];
    string       rd_tag_q[$];
    req_t        rq_exp_q[$];
    string       rq_tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_access_port uut (
        .clk(clk), .rst(rst), .cpu_off(cpu_off), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata),
        .cpu_rvalid(cpu_rvalid), .tgt_req(tgt_req), .tgt_we(tgt_we),
        .tgt_bus(tgt_bus), .tgt_dev(tgt_dev), .tgt_fn(tgt_fn), .tgt_reg(tgt_reg),
        .tgt_wdata(tgt_wdata), .tgt_be(tgt_be), .tgt_rdata(tgt_rdata)
    );

    function automatic logic [31:0] resp_of(logic [7:0] b, logic [4:0] d,
                                            logic [2:0] f, logic [7:0] r);
        return {b, 3'b101, d, 5'b0, f, r};
    endfunction

    // Target responder: answers read requests one cycle later.
    always @(posedge clk)
        if (tgt_req && !tgt_we) tgt_rdata <= resp_of(tgt_bus, tgt_dev, tgt_fn, tgt_reg);

    // Monitor: pops expectations as results appear.
    always @(negedge clk) begin
        if (!rst && cpu_rvalid) begin
            checks++;
            if (rd_exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected read response act=%h exp=none", cpu_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = rd_exp_q.pop_front();
                t = rd_tag_q.pop_front();
                if (cpu_rdata !== e) begin
                    errors++;
                    $display("FAIL %s read data act=%h exp=%h", t, cpu_rdata, e);
                end
            end
        end
        if (!rst && tgt_req) begin
            req_t a;
            a = '{tgt_we, tgt_bus, tgt_dev, tgt_fn, tgt_reg,
                  tgt_we ? tgt_wdata : 32'h0, tgt_be};
            checks++;
            if (rq_exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected target request act=%h exp=none", a);
            end else begin
                req_t e;
                string t;
                e = rq_exp_q.pop_front();
                t = rq_tag_q.pop_front();
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s target request act=%h exp=%h", t, a, e);
                end
            end
        end
    end

    task automatic cycle_drive(logic off, logic rd, logic wr, logic [31:0] d, logic [3:0] be);
        @(posedge clk); #1;
        cpu_off = off; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d; cpu_be = be;
        @(posedge clk); #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic wr_addr(logic [31:0] a);
        cycle_drive(1'b0, 1'b0, 1'b1, a, 4'hF);
    endtask

    task automatic rd_latch(logic [31:0] e, string tag);
        rd_exp_q.push_back(e); rd_tag_q.push_back(tag);
        cycle_drive(1'b0, 1'b1, 1'b0, '0, 4'hF);
    endtask

    task automatic rd_ones(string tag);
        rd_exp_q.push_back(32'hFFFF_FFFF); rd_tag_q.push_back(tag);
        cycle_drive(1'b1, 1'b1, 1'b0, '0, 4'hF);
    endtask

    task automatic rd_tgt(logic [7:0] b, logic [4:0] d, logic [2:0] f,
                          logic [7:0] r, logic [3:0] be, string tag);
        rq_exp_q.push_back('{1'b0, b, d, f, r, 32'h0, be}); rq_tag_q.push_back(tag);
        rd_exp_q.push_back(resp_of(b, d, f, r)); rd_tag_q.push_back(tag);
        cycle_drive(1'b1, 1'b1, 1'b0, '0, be);
    endtask

    task automatic wr_tgt(logic [7:0] b, logic [4:0] d, logic [2:0] f,
                          logic [7:0] r, logic [31:0] data, logic [3:0] be, string tag);
        rq_exp_q.push_back('{1'b1, b, d, f, r, data, be}); rq_tag_q.push_back(tag);
        cycle_drive(1'b1, 1'b0, 1'b1, data, be);
    endtask

    task automatic wr_dropped(logic [31:0] data);
        cycle_drive(1'b1, 1'b0, 1'b1, data, 4'hF);
    endtask

    task automatic finish_run();
        repeat (3) @(posedge clk);
        checks++;
        if (rd_exp_q.size() != 0 || rq_exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 missing results act=%0d/%0d exp=0/0",
                     rd_exp_q.size(), rq_exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;

        // R9: reset state
        rd_latch(32'h0, "R9");
        rd_ones("R9");
        wr_dropped(32'hA5A5_A5A5);

        // R3: enabled write, bus 0 dev 0 fn 1 reg 0x10
        wr_addr(32'h8000_0110);
        rd_latch(32'h8000_0110, "R1");
        rd_tgt(8'd0, 5'd0, 3'd1, 8'h10, 4'hF, "R3");

        // R1 R3 R8: junk low bits and reserved bits, partial masks
        wr_addr(32'hFE00_0A47);
        rd_latch(32'hFE00_0A47, "R1");
        rd_tgt(8'd0, 5'd1, 3'd2, 8'h44, 4'h3, "R3");
        wr_tgt(8'd0, 5'd1, 3'd2, 8'h44, 32'hDEAD_BEEF, 4'h5, "R8");

        // R4: enable clear keeps bus 0 dev 1, takes fn 3 reg 0x44
        wr_addr(32'h0000_3344);
        rd_latch(32'h0000_3344, "R4");
        rd_tgt(8'd0, 5'd1, 3'd3, 8'h44, 4'h8, "R4");

        // R5: bus 0 dev 5 -> root map (dev 5 empty) wins over child 1
        wr_addr(32'h8000_2800);
        rd_ones("R5");
        wr_dropped(32'h1111_2222);

        // R5: bus 2 dev 3 -> child 0, populated
        wr_addr(32'h8002_1800);
        rd_tgt(8'd2, 5'd3, 3'd0, 8'h00, 4'hF, "R5");
        wr_tgt(8'd2, 5'd3, 3'd0, 8'h00, 32'h1234_5678, 4'hC, "R8");

        // R7: bus 2 dev 8 -> child 0 map empty at 8 (child 2 not consulted)
        wr_addr(32'h8002_4000);
        rd_ones("R7");
        wr_dropped(32'h3333_4444);

        // R6: bus 7 missing
        wr_addr(32'h8007_0000);
        rd_ones("R6");
        wr_dropped(32'h5555_6666);
        rd_latch(32'h8007_0000, "R1");
        // R4 R6: enable-clear write does not revive the target
        wr_addr(32'h0000_0000);
        rd_ones("R4");

        // Recover and then reset mid-run (R9)
        wr_addr(32'h8000_0000);
        rd_tgt(8'd0, 5'd0, 3'd0, 8'h00, 4'hF, "R3");
        @(posedge clk); #1; rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        rd_latch(32'h0, "R9");
        rd_ones("R9");

        finish_run();
    end

endmodule